// File: doc/BRIEF.md
# Buffer Unit Free-Tag Pool with Chained Packet Storage

This block manages a shared packet store that is divided into fixed-size buffering units, each one identified by a tag. A first-in first-out pool holds the tags of the units that are free. A producer streams packet words into the block. The block takes a fresh tag from the pool whenever the current unit has no room left. It writes each word into the unit's address range, which is the tag shifted left by a fixed amount. It also stores a next-unit link inside each unit, so the units of one packet form a chain.

When the producer marks the last word, the block writes a terminator into the final unit's link word. On the next cycle it hands the chain head and the packet length to the consumer. The producer has stopped writing every unit of the chain before the consumer receives it, so the two sides never access the same region at the same time.

The consumer reads the store through a read port. When it is finished with a packet, it returns each tag to the pool. The store is modelled as an internal array.

Top module: `bup_pool`

## Requirements
- R1: After reset the pool holds every tag from 0 to 2^TAG_W-1, and the tags are issued in ascending order. `pool_full` is 1, and `pool_empty`, `alloc_fail`, `done_valid` and `ovf_err` are all 0.
- R2: Tags leave the pool in the order they entered it. The initial fill comes first, followed by returned tags in the order of their `ret_valid` cycles.
- R3: Word w of unit t sits at address t*2^UNIT_LOG2 + w. Word 0 is the link word. A packet's data words fill offsets 1 to 2^UNIT_LOG2-1 of each unit in arrival order.
- R4: A data word that arrives when no packet is open opens a fresh unit, and so does a word that arrives when the current unit's data offsets are all used. When a unit is chained this way, the link word of the previous unit of the same packet receives the new tag, zero-extended to DATA_W.
- R5: The link word of the last unit of every completed packet holds all ones (DATA_W bits). This value can never equal a tag.
- R6: `done_valid` is high for exactly the one cycle after the clock edge that accepts a word with `wr_last` set. During that cycle `done_head` is the packet's first tag and `done_len` is its number of data words.
- R7: Suppose a word needs a fresh unit while the pool is empty. The word is dropped, `alloc_fail` is high for the following cycle, and the open packet is left exactly as it was. A later word resumes the packet where it stopped.
- R8: A tag returned while the pool is full is dropped. It also sets `ovf_err`, which stays set until reset.
- R9: `pool_empty` is high exactly when no tag is free, and `pool_full` is high exactly when all 2^TAG_W tags are free. The two flags are never high together.
- R10: With RD_REG=1, `rd_data` shows the word at `rd_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Producer offers a data word |
| wr_last | input | 1 | Offered word ends the packet |
| wr_data | input | DATA_W | Producer data word |
| alloc_fail | output | 1 | Previous word was dropped because no tag was free |
| done_valid | output | 1 | Completed packet descriptor is valid |
| done_head | output | TAG_W | First tag of the completed chain |
| done_len | output | TAG_W+UNIT_LOG2 | Data words in the completed packet |
| ret_valid | input | 1 | Consumer returns a tag |
| ret_tag | input | TAG_W | Tag being returned |
| pool_empty | output | 1 | No free tag |
| pool_full | output | 1 | Every tag is free |
| ovf_err | output | 1 | Sticky: a returned tag found the pool full |
| rd_addr | input | TAG_W+UNIT_LOG2 | Consumer read address |
| rd_data | output | DATA_W | Consumer read data |

## Verification
The bench builds the block with TAG_W=3, UNIT_LOG2=2 and DATA_W=8. That gives eight units of three data words each, with an 8-bit terminator of 0xFF.

At this size every packet length from one word up to the whole store (24 words) can be swept. Each sweep walks the chain through the read port and returns the tags in alternating orders, which reorders the pool. The small pool also makes it quick to drain the pool completely. That exposes allocation failure both at a packet's start and in the middle of a packet, and it lets the bench overfill the pool with a surplus returned tag.

// File: rtl/bup_pkg.sv
package bup_pkg;

   // Per-word decision of the chain builder
   typedef enum logic [1:0] {
      ACT_IDLE   = 2'd0,
      ACT_APPEND = 2'd1,
      ACT_OPEN   = 2'd2,
      ACT_FAIL   = 2'd3
   } bup_act_e;

endpackage

// File: rtl/bup_tag_fifo.sv
module bup_tag_fifo #(
   parameter int TAG_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pop,
   input  logic             push,
   input  logic [TAG_W-1:0] push_tag,
   output logic [TAG_W-1:0] head_tag,
   output logic             empty,
   output logic             full,
   output logic             ovf
);
   localparam int DEPTH = 1 << TAG_W;
   localparam int CNT_W = TAG_W + 1;

   logic [TAG_W-1:0] slots [DEPTH];
   logic [TAG_W-1:0] rd_ptr, wr_ptr;
   logic [CNT_W-1:0] cnt;
   logic             do_pop, do_push;

   assign empty    = (cnt == '0);
   assign full     = (cnt == CNT_W'(DEPTH));
   assign head_tag = slots[rd_ptr];
   assign do_pop   = pop && !empty;
   assign do_push  = push && !full;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) slots[i] <= TAG_W'(i);
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= CNT_W'(DEPTH);
         ovf    <= 1'b0;
      end else begin
         if (do_push) begin
            slots[wr_ptr] <= push_tag;
            wr_ptr        <= wr_ptr + 1'b1;
         end
         if (do_pop) rd_ptr <= rd_ptr + 1'b1;
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
         if (push && full) ovf <= 1'b1;
      end
   end
endmodule

// File: rtl/bup_chain_builder.sv
module bup_chain_builder
   import bup_pkg::*;
#(
   parameter int TAG_W     = 8,
   parameter int UNIT_LOG2 = 2,
   parameter int DATA_W    = 16
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            wr_valid,
   input  logic                            wr_last,
   input  logic [DATA_W-1:0]               wr_data,
   input  logic                            pool_empty,
   input  logic [TAG_W-1:0]                pool_head,
   output logic                            pool_pop,
   output logic                            dw_en,
   output logic [TAG_W+UNIT_LOG2-1:0]      dw_addr,
   output logic [DATA_W-1:0]               dw_data,
   output logic                            lw_en,
   output logic [TAG_W+UNIT_LOG2-1:0]      lw_addr,
   output logic [DATA_W-1:0]               lw_data,
   output logic                            tw_en,
   output logic [TAG_W+UNIT_LOG2-1:0]      tw_addr,
   output logic                            alloc_fail,
   output logic                            done_valid,
   output logic [TAG_W-1:0]                done_head,
   output logic [TAG_W+UNIT_LOG2-1:0]      done_len
);
   localparam int ADDR_W = TAG_W + UNIT_LOG2;

   logic                 active;
   logic [TAG_W-1:0]     cur_tag, head_tag;
   logic [UNIT_LOG2-1:0] off;
   logic [ADDR_W-1:0]    len;

   bup_act_e             act;
   logic                 need_new, accept;
   logic [TAG_W-1:0]     tgt_tag, pkt_head;
   logic [UNIT_LOG2-1:0] tgt_off;
   logic [ADDR_W-1:0]    pkt_len;

   always_comb begin
      need_new = !active || (off == '0);
      if (!wr_valid)                  act = ACT_IDLE;
      else if (need_new && pool_empty) act = ACT_FAIL;
      else if (need_new)              act = ACT_OPEN;
      else                            act = ACT_APPEND;
      accept   = (act == ACT_OPEN) || (act == ACT_APPEND);
      tgt_tag  = (act == ACT_OPEN) ? pool_head : cur_tag;
      tgt_off  = (act == ACT_OPEN) ? UNIT_LOG2'(1) : off;
      pkt_head = active ? head_tag : pool_head;
      pkt_len  = (active ? len : '0) + ADDR_W'(1);
   end

   assign pool_pop = (act == ACT_OPEN);
   assign dw_en    = accept;
   assign dw_addr  = {tgt_tag, tgt_off};
   assign dw_data  = wr_data;
   assign lw_en    = (act == ACT_OPEN) && active;
   assign lw_addr  = {cur_tag, {UNIT_LOG2{1'b0}}};
   assign lw_data  = {{(DATA_W-TAG_W){1'b0}}, pool_head};
   assign tw_en    = accept && wr_last;
   assign tw_addr  = {tgt_tag, {UNIT_LOG2{1'b0}}};

   always_ff @(posedge clk) begin
      if (rst) begin
         active     <= 1'b0;
         cur_tag    <= '0;
         head_tag   <= '0;
         off        <= '0;
         len        <= '0;
         alloc_fail <= 1'b0;
         done_valid <= 1'b0;
         done_head  <= '0;
         done_len   <= '0;
      end else begin
         alloc_fail <= (act == ACT_FAIL);
         done_valid <= accept && wr_last;
         if (accept && wr_last) begin
            done_head <= pkt_head;
            done_len  <= pkt_len;
            active    <= 1'b0;
         end else if (accept) begin
            active   <= 1'b1;
            cur_tag  <= tgt_tag;
            off      <= tgt_off + 1'b1;
            head_tag <= pkt_head;
            len      <= pkt_len;
         end
      end
   end
endmodule

// File: rtl/bup_unit_buffer.sv
module bup_unit_buffer #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16,
   parameter int RD_REG = 1
) (
   input  logic              clk,
   input  logic              dw_en,
   input  logic [ADDR_W-1:0] dw_addr,
   input  logic [DATA_W-1:0] dw_data,
   input  logic              lw_en,
   input  logic [ADDR_W-1:0] lw_addr,
   input  logic [DATA_W-1:0] lw_data,
   input  logic              tw_en,
   input  logic [ADDR_W-1:0] tw_addr,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int WORDS = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (dw_en) mem[dw_addr] <= dw_data;
      if (lw_en) mem[lw_addr] <= lw_data;
      if (tw_en) mem[tw_addr] <= '1;
   end

   generate
      if (RD_REG != 0) begin : g_rd_reg
         always_ff @(posedge clk) rd_data <= mem[rd_addr];
      end else begin : g_rd_comb
         assign rd_data = mem[rd_addr];
      end
   endgenerate
endmodule

// File: rtl/bup_pool.sv
module bup_pool #(
   parameter int TAG_W     = 8,
   parameter int UNIT_LOG2 = 2,
   parameter int DATA_W    = 16,
   parameter int RD_REG    = 1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_valid,
   input  logic                       wr_last,
   input  logic [DATA_W-1:0]          wr_data,
   output logic                       alloc_fail,
   output logic                       done_valid,
   output logic [TAG_W-1:0]           done_head,
   output logic [TAG_W+UNIT_LOG2-1:0] done_len,
   input  logic                       ret_valid,
   input  logic [TAG_W-1:0]           ret_tag,
   output logic                       pool_empty,
   output logic                       pool_full,
   output logic                       ovf_err,
   input  logic [TAG_W+UNIT_LOG2-1:0] rd_addr,
   output logic [DATA_W-1:0]          rd_data
);
   localparam int ADDR_W = TAG_W + UNIT_LOG2;

   generate
      if (DATA_W <= TAG_W) begin : g_bad_data_w
         $error("bup_pool: DATA_W must exceed TAG_W so the terminator is not a tag");
      end
      if (UNIT_LOG2 < 1) begin : g_bad_unit
         $error("bup_pool: UNIT_LOG2 must be at least 1");
      end
      if (RD_REG < 0 || RD_REG > 1) begin : g_bad_rd
         $error("bup_pool: RD_REG must be 0 or 1");
      end
   endgenerate

   logic              pool_pop;
   logic [TAG_W-1:0]  pool_head;
   logic              dw_en, lw_en, tw_en;
   logic [ADDR_W-1:0] dw_addr, lw_addr, tw_addr;
   logic [DATA_W-1:0] dw_data, lw_data;

   bup_tag_fifo #(.TAG_W(TAG_W)) u_pool (
      .clk      (clk),
      .rst      (rst),
      .pop      (pool_pop),
      .push     (ret_valid),
      .push_tag (ret_tag),
      .head_tag (pool_head),
      .empty    (pool_empty),
      .full     (pool_full),
      .ovf      (ovf_err)
   );

   bup_chain_builder #(.TAG_W(TAG_W), .UNIT_LOG2(UNIT_LOG2), .DATA_W(DATA_W)) u_build (
      .clk        (clk),
      .rst        (rst),
      .wr_valid   (wr_valid),
      .wr_last    (wr_last),
      .wr_data    (wr_data),
      .pool_empty (pool_empty),
      .pool_head  (pool_head),
      .pool_pop   (pool_pop),
      .dw_en      (dw_en),
      .dw_addr    (dw_addr),
      .dw_data    (dw_data),
      .lw_en      (lw_en),
      .lw_addr    (lw_addr),
      .lw_data    (lw_data),
      .tw_en      (tw_en),
      .tw_addr    (tw_addr),
      .alloc_fail (alloc_fail),
      .done_valid (done_valid),
      .done_head  (done_head),
      .done_len   (done_len)
   );

   bup_unit_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_REG(RD_REG)) u_buf (
      .clk     (clk),
      .dw_en   (dw_en),
      .dw_addr (dw_addr),
      .dw_data (dw_data),
      .lw_en   (lw_en),
      .lw_addr (lw_addr),
      .lw_data (lw_data),
      .tw_en   (tw_en),
      .tw_addr (tw_addr),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/bup_pool_chk.sv
module bup_pool_chk #(
   parameter int LEN_W = 10
) (
   input logic             clk,
   input logic             rst,
   input logic             wr_valid,
   input logic             alloc_fail,
   input logic             done_valid,
   input logic [LEN_W-1:0] done_len,
   input logic             pool_empty,
   input logic             pool_full,
   input logic             ovf_err
);
   a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(pool_empty && pool_full));

   a_r9_full_holds_without_alloc: assert property (@(posedge clk) disable iff (rst)
      (pool_full && !wr_valid) |=> pool_full);

   a_r7_fail_needs_empty: assert property (@(posedge clk) disable iff (rst)
      alloc_fail |-> $past(pool_empty));

   a_r7_fail_excludes_done: assert property (@(posedge clk) disable iff (rst)
      !(alloc_fail && done_valid));

   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
      ovf_err |=> ovf_err);

   a_r6_done_len_nonzero: assert property (@(posedge clk) disable iff (rst)
      done_valid |-> (done_len != '0));

   a_r6_done_single_cycle_per_word: assert property (@(posedge clk) disable iff (rst)
      done_valid |-> $past(wr_valid));
endmodule

bind bup_pool bup_pool_chk #(.LEN_W(TAG_W + UNIT_LOG2)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .wr_valid   (wr_valid),
   .alloc_fail (alloc_fail),
   .done_valid (done_valid),
   .done_len   (done_len),
   .pool_empty (pool_empty),
   .pool_full  (pool_full),
   .ovf_err    (ovf_err)
);

// File: tb/bup_pool_tb.sv
`timescale 1ns/1ps
module bup_pool_tb;
   localparam int TAG_W     = 3;
   localparam int UNIT_LOG2 = 2;
   localparam int DATA_W    = 8;
   localparam int ADDR_W    = TAG_W + UNIT_LOG2;
   localparam int NTAG      = 1 << TAG_W;
   localparam int UW        = 1 << UNIT_LOG2;
   localparam int DPU       = UW - 1;
   localparam int TERM      = (1 << DATA_W) - 1;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              wr_valid = 1'b0, wr_last = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              alloc_fail, done_valid;
   logic [TAG_W-1:0]  done_head;
   logic [ADDR_W-1:0] done_len;
   logic              ret_valid = 1'b0;
   logic [TAG_W-1:0]  ret_tag = '0;
   logic              pool_empty, pool_full, ovf_err;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [DATA_W-1:0] rd_data;

   int checks = 0;
   int errors = 0;
   int mq [NTAG];
   int mh = 0, mt = 0;
   int tags [NTAG];

   always #2.5 clk = ~clk;

   bup_pool #(.TAG_W(TAG_W), .UNIT_LOG2(UNIT_LOG2), .DATA_W(DATA_W), .RD_REG(1)) u_dut (
      .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_last(wr_last), .wr_data(wr_data),
      .alloc_fail(alloc_fail), .done_valid(done_valid), .done_head(done_head),
      .done_len(done_len), .ret_valid(ret_valid), .ret_tag(ret_tag),
      .pool_empty(pool_empty), .pool_full(pool_full), .ovf_err(ovf_err),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int model_pop();
      int t = mq[mh];
      mh = (mh + 1) % NTAG;
      return t;
   endfunction

   function automatic void model_push(input int t);
      mq[mt] = t;
      mt = (mt + 1) % NTAG;
   endfunction

   function automatic int pat(input int l, input int i);
      return (l * 11 + i * 3 + 1) % 256;
   endfunction

   task automatic send(input int d, input bit last);
      wr_valid = 1'b1; wr_last = last; wr_data = DATA_W'(d);
      @(negedge clk);
      wr_valid = 1'b0; wr_last = 1'b0;
   endtask

   task automatic give_back(input int t);
      ret_valid = 1'b1; ret_tag = TAG_W'(t);
      @(negedge clk);
      ret_valid = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      rd_addr = ADDR_W'(a);
      @(negedge clk);
      v = int'(rd_data);
   endtask

   // Sends an L-word packet that is expected to succeed, then checks descriptor and chain
   task automatic run_packet(input int l, input int salt);
      int k, v;
      k = (l + DPU - 1) / DPU;
      for (int u = 0; u < k; u++) tags[u] = model_pop();
      for (int i = 0; i < l; i++) begin
         send(pat(l + salt, i), i == l - 1);
         if (i != l - 1) check("R6 no early done", int'(done_valid), 0);
      end
      check("R6 done_valid", int'(done_valid), 1);
      check("R6 R1 R2 done_head", int'(done_head), tags[0]);
      check("R6 done_len", int'(done_len), l);
      @(negedge clk);
      check("R6 done pulse ends", int'(done_valid), 0);
      for (int u = 0; u < k; u++) begin
         rd(tags[u] * UW, v);
         if (u == k - 1) check("R5 terminator link", v, TERM);
         else            check("R4 R2 link word", v, tags[u + 1]);
         for (int w = 1; w < UW; w++) begin
            int idx = u * DPU + w - 1;
            if (idx < l) begin
               rd(tags[u] * UW + w, v);
               check("R3 R10 data word", v, pat(l + salt, idx));
            end
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int k;
      for (int i = 0; i < NTAG; i++) mq[i] = i;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1 pool_full at reset", int'(pool_full), 1);
      check("R1 pool_empty at reset", int'(pool_empty), 0);
      check("R1 done_valid at reset", int'(done_valid), 0);
      check("R1 alloc_fail at reset", int'(alloc_fail), 0);
      check("R1 ovf_err at reset", int'(ovf_err), 0);

      // Sweep of every packet length that fits the store
      for (int l = 1; l <= NTAG * DPU; l++) begin
         run_packet(l, 0);
         k = (l + DPU - 1) / DPU;
         if (k == NTAG) check("R9 empty after whole store", int'(pool_empty), 1);
         if (l % 2 == 1) begin
            for (int u = k - 1; u >= 0; u--) begin give_back(tags[u]); model_push(tags[u]); end
         end else begin
            for (int u = 0; u < k; u++) begin give_back(tags[u]); model_push(tags[u]); end
         end
         check("R9 full after returns", int'(pool_full), 1);
      end

      // Drain the pool, then a new packet start must fail
      run_packet(NTAG * DPU, 5);
      check("R9 pool_empty when drained", int'(pool_empty), 1);
      send(8'h33, 1'b0);
      check("R7 alloc_fail at start", int'(alloc_fail), 1);
      check("R7 no done on fail", int'(done_valid), 0);
      @(negedge clk);
      check("R7 alloc_fail one cycle", int'(alloc_fail), 0);
      give_back(tags[0]); model_push(tags[0]);
      check("R9 not empty after return", int'(pool_empty), 0);
      run_packet(1, 40);

      // Failure in the middle of a packet, then resume
      give_back(tags[0]); model_push(tags[0]);
      begin
         int t0, t1, v;
         t0 = model_pop();
         for (int i = 0; i < DPU; i++) send(pat(50, i), 1'b0);
         send(pat(50, DPU), 1'b1);
         check("R7 mid-packet alloc_fail", int'(alloc_fail), 1);
         check("R7 mid-packet no done", int'(done_valid), 0);
         t1 = 1;
         for (int i = 0; i < NTAG; i++) if (i != t0 && t1 == 1) t1 = i + 2;
         t1 = t1 - 2;
         give_back(t1); model_push(t1);
         t1 = model_pop();
         send(pat(50, DPU), 1'b1);
         check("R7 resumed done", int'(done_valid), 1);
         check("R7 resumed head", int'(done_head), t0);
         check("R7 resumed len", int'(done_len), DPU + 1);
         rd(t0 * UW, v);
         check("R4 chained after fail", v, t1);
         rd(t1 * UW, v);
         check("R5 terminator after resume", v, TERM);
         rd(t1 * UW + 1, v);
         check("R3 resumed word", v, pat(50, DPU));
         for (int i = 0; i < NTAG; i++) begin give_back(i); model_push(i); end
      end
      check("R9 full before surplus", int'(pool_full), 1);
      check("R8 ovf clear before surplus", int'(ovf_err), 0);
      give_back(3);
      check("R8 ovf_err set", int'(ovf_err), 1);
      check("R8 pool still full", int'(pool_full), 1);
      repeat (2) @(negedge clk);
      check("R8 ovf_err sticky", int'(ovf_err), 1);
      run_packet(NTAG * DPU, 9);
      check("R8 surplus dropped: empty after store", int'(pool_empty), 1);
      send(8'h11, 1'b1);
      check("R8 surplus dropped: next fails", int'(alloc_fail), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule